// File: doc/BRIEF.md
# FSK fractional-N divide control

This block is the digital half of a fractional-N feedback divider that can also send two-level frequency shift keying. Configuration inputs supply an integer divide value, a 12-bit fractional denominator and a 22-bit numerator word. The low 12 bits of that word set the centre fraction and the upper 10 bits set a deviation. On every reference clock edge a first-order accumulator adds the active numerator, modulo the denominator, to a stored residue. The divider is told to count N+1 on the cycles where the residue wraps and N on all other cycles, so the long-run average divide ratio is N + numerator/denominator.

A serial modulation input moves the active numerator between centre minus deviation and centre plus deviation. That input is synchronised into the reference domain first. The deviation may never change the integer part of the ratio. If either keyed value would leave the range 0 to denominator−1, a configuration-error flag is raised and the centre value is used in both symbol states. A wide-fraction mode bit turns keying off, and the centre value is then used whatever the modulation input does.

The divide value is produced on every cycle with no handshake. The divider consumes it unconditionally, so the block has no back-pressure: it applies no stall and accepts none. All configuration pins are plain levels that are sampled on each edge.

Top module: `fsk_fracn_ctrl`

## Requirements
- R1: While reset is low and on the first edge after it is released, the residue is zero and the divide output equals the integer field N.
- R2: On each edge the active numerator is added to the residue. If the sum is at least the denominator, the denominator is subtracted and the output becomes N+1 for the next cycle. Otherwise the output becomes N.
- R3: The centre is frac_num_i[11:0] and the deviation is frac_num_i[21:12]. With keying active, a synchronised modulation value of 1 selects centre+deviation and a value of 0 selects centre−deviation.
- R4: The modulation input passes through two reference-clock flops. A level applied before edge k changes the numerator used by the accumulator at edge k+2.
- R5: When centre+deviation ≥ denominator or deviation > centre while keying is active, cfg_err_o is 1 and the centre value is used for both symbols.
- R6: A denominator of zero, or a centre ≥ denominator, raises cfg_err_o and forces the active numerator to zero, so the output stays N.
- R7: With wide_frac_i = 1, keying is off. The centre value is used, the modulation input has no effect on the output sequence, and no deviation range error is flagged.
- R8: If the stored residue is not below the current denominator (for example after the denominator is lowered), the next edge clears the residue to zero and gives N for that cycle.
- R9: Over any run of D consecutive cycles with a constant valid numerator M and denominator D, exactly M cycles give N+1.
- R10: cfg_err_o depends only on the configuration fields and the mode bit, and never on the modulation input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock; one accumulator step per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| int_n_i | input | N_W (16) | Integer part N of the divide ratio |
| frac_num_i | input | 22 | Bits 11:0 centre numerator, bits 21:12 deviation |
| frac_den_i | input | 12 | Fractional denominator |
| wide_frac_i | input | 1 | 1 = wide fraction mode, keying disabled |
| fsk_data_i | input | 1 | Asynchronous modulation symbol |
| div_val_o | output | N_W+1 (17) | Divide value for the current cycle, N or N+1 |
| cfg_err_o | output | 1 | Configuration out of range; fallback numerator in use |

## Verification
Two events can land on the same edge. A synchronised symbol change can reach the numerator selector on the edge where the residue wraps, and the stale-residue clear can fall on the edge where the numerator or denominator also changes. Random configurations are held for 40 cycles while the modulation input is redrawn on every cycle, so symbol changes meet wraps many times. Directed cases lower the denominator in the same cycle as a new numerator. A cycle-level bench model of the two-flop delay and the wrap rule judges the divide output after every edge, and exact wrap counts over whole denominator periods confirm the average ratio.

// File: rtl/fsk_fracn_pkg.sv
package fsk_fracn_pkg;
  // Width of the fractional numerator (centre) and denominator.
  localparam int FRAC_W = 12;
  // Width of the deviation field above the centre in the numerator word.
  localparam int DEV_W  = 10;
  // Full numerator register word.
  localparam int NUM_W  = FRAC_W + DEV_W;
  // Zero-extension needed to line the deviation up with the centre.
  localparam int PAD_W  = FRAC_W - DEV_W;

  typedef logic [FRAC_W-1:0] frac_t;
  typedef logic [DEV_W-1:0]  dev_t;

  // Numerator-selection outcome, exposed for the checker.
  typedef enum logic [1:0] {
    SEL_ZERO   = 2'd0,  // denominator or centre unusable
    SEL_CENTRE = 2'd1,  // keying off or deviation out of range
    SEL_KEYED  = 2'd2   // centre +/- deviation in use
  } sel_kind_e;
endpackage

// File: rtl/fsk_data_sync.sv
module fsk_data_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  // One flop per stage, each fed from the one before it.
  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) chain_q[s] <= 1'b0;
        else        chain_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) chain_q[s] <= 1'b0;
        else        chain_q[s] <= chain_q[s-1];
      end
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/fsk_num_select.sv
module fsk_num_select
  import fsk_fracn_pkg::*;
(
  input  frac_t     centre_i,
  input  dev_t      dev_i,
  input  frac_t     den_i,
  input  logic      wide_i,
  input  logic      sym_i,
  output frac_t     num_o,
  output logic      err_o,
  output sel_kind_e kind_o
);
  logic [FRAC_W:0] up_sum;
  frac_t           dev_ext;
  frac_t           dn_val;
  logic            base_bad;
  logic            up_ok;
  logic            dn_ok;

  assign dev_ext  = {{PAD_W{1'b0}}, dev_i};
  assign up_sum   = {1'b0, centre_i} + {1'b0, dev_ext};
  assign dn_val   = centre_i - dev_ext;

  // Centre must be a proper fraction of a non-zero denominator.
  assign base_bad = (den_i == '0) || (centre_i >= den_i);
  // Both keyed values must stay inside 0 .. den-1.
  assign up_ok    = (up_sum < {1'b0, den_i});
  assign dn_ok    = (dev_ext <= centre_i);

  always_comb begin
    kind_o = SEL_KEYED;
    err_o  = 1'b0;
    num_o  = sym_i ? up_sum[FRAC_W-1:0] : dn_val;
    if (base_bad) begin
      kind_o = SEL_ZERO;
      err_o  = 1'b1;
      num_o  = '0;
    end else if (wide_i) begin
      kind_o = SEL_CENTRE;
      num_o  = centre_i;
    end else if (!(up_ok && dn_ok)) begin
      kind_o = SEL_CENTRE;
      err_o  = 1'b1;
      num_o  = centre_i;
    end
  end
endmodule

// File: rtl/fsk_frac_accum.sv
module fsk_frac_accum
  import fsk_fracn_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  frac_t num_i,
  input  frac_t den_i,
  output frac_t acc_o,
  output logic  carry_o
);
  frac_t           acc_q;
  logic            carry_q;
  logic [FRAC_W:0] sum;
  logic [FRAC_W:0] wrapped;
  logic            stale;
  logic            wrap;

  // A residue left over from a larger denominator is unusable.
  assign stale   = (acc_q >= den_i);
  assign sum     = {1'b0, acc_q} + {1'b0, num_i};
  assign wrap    = (sum >= {1'b0, den_i});
  assign wrapped = sum - {1'b0, den_i};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q   <= '0;
      carry_q <= 1'b0;
    end else if (stale) begin
      acc_q   <= '0;
      carry_q <= 1'b0;
    end else if (wrap) begin
      acc_q   <= wrapped[FRAC_W-1:0];
      carry_q <= 1'b1;
    end else begin
      acc_q   <= sum[FRAC_W-1:0];
      carry_q <= 1'b0;
    end
  end

  assign acc_o   = acc_q;
  assign carry_o = carry_q;
endmodule

// File: rtl/fsk_fracn_ctrl.sv
module fsk_fracn_ctrl
  import fsk_fracn_pkg::*;
#(
  parameter int N_W         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_ref,
  input  logic             rst_n,
  input  logic [N_W-1:0]   int_n_i,
  input  logic [NUM_W-1:0] frac_num_i,
  input  logic [FRAC_W-1:0] frac_den_i,
  input  logic             wide_frac_i,
  input  logic             fsk_data_i,
  output logic [N_W:0]     div_val_o,
  output logic             cfg_err_o
);
  frac_t     centre;
  dev_t      dev;
  logic      sym_s;
  frac_t     num_act;
  sel_kind_e sel_kind;
  frac_t     acc;
  logic      carry;

  assign centre = frac_num_i[FRAC_W-1:0];
  assign dev    = frac_num_i[NUM_W-1:FRAC_W];

  fsk_data_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk_ref),
    .rst_n (rst_n),
    .d_i   (fsk_data_i),
    .q_o   (sym_s)
  );

  fsk_num_select u_sel (
    .centre_i (centre),
    .dev_i    (dev),
    .den_i    (frac_den_i),
    .wide_i   (wide_frac_i),
    .sym_i    (sym_s),
    .num_o    (num_act),
    .err_o    (cfg_err_o),
    .kind_o   (sel_kind)
  );

  fsk_frac_accum u_acc (
    .clk     (clk_ref),
    .rst_n   (rst_n),
    .num_i   (num_act),
    .den_i   (frac_den_i),
    .acc_o   (acc),
    .carry_o (carry)
  );

  assign div_val_o = {1'b0, int_n_i} + {{N_W{1'b0}}, carry};
endmodule

// File: rtl/fsk_fracn_checker.sv
module fsk_fracn_checker
  import fsk_fracn_pkg::*;
#(
  parameter int N_W         = 16,
  parameter int SYNC_STAGES = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_W-1:0]   int_n,
  input logic [NUM_W-1:0] num_word,
  input frac_t            den,
  input logic             wide,
  input logic             data_in,
  input logic             sym_s,
  input frac_t            num_act,
  input frac_t            acc,
  input logic             carry,
  input logic [N_W:0]     div_val,
  input logic             cfg_err
);
  logic [1:0] since_rst;
  always_ff @(posedge clk) begin
    if (!rst_n)               since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  // R1: first edge out of reset still shows the plain integer.
  a_r1_reset_div: assert property (@(posedge clk)
    $rose(rst_n) |-> (div_val == {1'b0, int_n}));

  // R2: a zero numerator can never make the residue wrap.
  a_r2_zero_num_no_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (num_act == '0) |=> !carry);

  // R4: symbol seen by the selector is the input two edges back.
  if (SYNC_STAGES == 2) begin : g_sync_chk
    a_r4_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst >= 2'd2) |-> (sym_s == $past(data_in, 2)));
  end

  // R6: zero denominator never produces N+1.
  a_r6_zero_den_no_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (den == '0) |=> !carry);

  // R7: in wide mode the symbol cannot move the numerator.
  a_r7_wide_ignores_data: assert property (@(posedge clk) disable iff (!rst_n)
    (wide && $stable(wide) && $stable(num_word) && $stable(den))
      |-> $stable(num_act));

  // R8: with a steady denominator the residue stays below it.
  a_r8_residue_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    ((den != '0) && $stable(den)) |-> (acc < den));

  // R10: the error flag is blind to the symbol.
  a_r10_err_data_indep: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(num_word) && $stable(den) && $stable(wide)) |-> $stable(cfg_err));
endmodule

bind fsk_fracn_ctrl fsk_fracn_checker #(
  .N_W         (N_W),
  .SYNC_STAGES (SYNC_STAGES)
) u_chk (
  .clk      (clk_ref),
  .rst_n    (rst_n),
  .int_n    (int_n_i),
  .num_word (frac_num_i),
  .den      (frac_den_i),
  .wide     (wide_frac_i),
  .data_in  (fsk_data_i),
  .sym_s    (sym_s),
  .num_act  (num_act),
  .acc      (acc),
  .carry    (carry),
  .div_val  (div_val_o),
  .cfg_err  (cfg_err_o)
);

// File: tb/fsk_fracn_ctrl_test.sv
`timescale 1ns/1ps
module fsk_fracn_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] int_n = 16'd100;
  logic [21:0] num_w = '0;
  logic [11:0] den = 12'd8;
  logic        wide = 1'b0;
  logic        data = 1'b0;
  logic [16:0] div_o;
  logic        err_o;

  int checks = 0;
  int errors = 0;
  bit mon_on = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fsk_fracn_ctrl uut (
    .clk_ref     (clk),
    .rst_n       (rst_n),
    .int_n_i     (int_n),
    .frac_num_i  (num_w),
    .frac_den_i  (den),
    .wide_frac_i (wide),
    .fsk_data_i  (data),
    .div_val_o   (div_o),
    .cfg_err_o   (err_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Expected numerator and error from the requirement text.
  function automatic void ref_sel(input int c, input int d, input int n,
                                  input bit w, input bit s,
                                  output int eff, output bit er);
    if (n == 0 || c >= n)          begin eff = 0; er = 1; end
    else if (w)                    begin eff = c; er = 0; end
    else if (c + d >= n || d > c)  begin eff = c; er = 1; end
    else                           begin eff = s ? c + d : c - d; er = 0; end
  endfunction

  // Cycle model: two-flop symbol delay, wrap rule, stale clear.
  bit m_s1, m_s2, m_carry;
  int m_acc;
  always @(posedge clk) begin : model
    int e, s;
    bit er;
    if (!rst_n) begin
      m_s1 <= 0; m_s2 <= 0; m_acc <= 0; m_carry <= 0;
    end else begin
      ref_sel(num_w[11:0], num_w[21:12], den, wide, m_s2, e, er);
      m_s1 <= data;
      m_s2 <= m_s1;
      if (m_acc >= den) begin m_acc <= 0; m_carry <= 0; end
      else begin
        s = m_acc + e;
        if (s >= den) begin m_acc <= s - den; m_carry <= 1; end
        else          begin m_acc <= s;       m_carry <= 0; end
      end
    end
  end

  always @(posedge clk) begin : monitor
    int e;
    bit er;
    #1;
    if (mon_on) begin
      ref_sel(num_w[11:0], num_w[21:12], den, wide, m_s2, e, er);
      chk(div_o == int_n + m_carry, "R2 div", div_o, int_n + m_carry);
      chk(err_o == er, "R5 err", err_o, er);
    end
  end

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic count_n1(input int n, output int c);
    c = 0;
    repeat (n) begin
      @(posedge clk); #1;
      if (div_o == int_n + 1) c++;
    end
  endtask

  task automatic set_cfg(input int c, input int d, input int n, input bit w);
    num_w = {d[9:0], c[11:0]};
    den = n[11:0];
    wide = w;
  endtask

  initial begin : watchdog
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL R2 watchdog actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    int c;
    void'($urandom(32'd20240611));
    // R1 reset state
    set_cfg(2, 2, 8, 0);
    repeat (2) @(posedge clk);
    #1 chk(div_o == 17'd100, "R1 in reset", div_o, 100);
    do_reset();
    @(posedge clk); #1;
    chk(div_o == 17'd100, "R1 after release", div_o, 100);
    mon_on = 1;

    // R4 synchroniser latency: eff 0 -> 4 with den 8
    repeat (3) @(negedge clk);
    data = 1;
    repeat (3) @(posedge clk);
    #1 chk(div_o == 17'd100, "R4 edge3", div_o, 100);
    @(posedge clk); #1;
    chk(div_o == 17'd101, "R4 edge4", div_o, 101);

    // R3 / R9 keyed numerators over a full period
    @(negedge clk); set_cfg(20, 10, 100, 0); data = 1;
    repeat (4) @(negedge clk);
    chk(err_o == 0, "R10 err data1", err_o, 0);
    count_n1(100, c); chk(c == 30, "R3 plus R9", c, 30);
    @(negedge clk); data = 0;
    repeat (4) @(negedge clk);
    chk(err_o == 0, "R10 err data0", err_o, 0);
    count_n1(100, c); chk(c == 10, "R3 minus R9", c, 10);

    // R5 deviation out of range: centre 5 held
    @(negedge clk); set_cfg(5, 6, 100, 0); data = 1;
    repeat (4) @(negedge clk);
    chk(err_o == 1, "R5 err data1", err_o, 1);
    count_n1(100, c); chk(c == 5, "R5 centre held", c, 5);
    @(negedge clk); data = 0;
    repeat (4) @(negedge clk);
    chk(err_o == 1, "R10 err data0", err_o, 1);

    // R6 zero denominator and centre >= den
    @(negedge clk); set_cfg(3, 0, 0, 0);
    #1 chk(err_o == 1, "R6 den0 err", err_o, 1);
    count_n1(20, c); chk(c == 0, "R6 den0 no N+1", c, 0);
    @(negedge clk); set_cfg(12, 0, 10, 0);
    #1 chk(err_o == 1, "R6 centre>=den err", err_o, 1);
    count_n1(20, c); chk(c == 0, "R6 centre>=den no N+1", c, 0);

    // R7 wide mode: data toggles, centre 7 of 8, range error ignored
    @(negedge clk); set_cfg(7, 5, 8, 1);
    #1 chk(err_o == 0, "R7 no range err", err_o, 0);
    repeat (3) @(negedge clk);
    c = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); data = ~data;
      @(posedge clk); #1;
      if (div_o == int_n + 1) c++;
    end
    chk(c == 7, "R7 wide count", c, 7);

    // R8 stale residue after denominator drop
    @(negedge clk); set_cfg(99, 0, 100, 0);
    repeat (3) @(negedge clk);
    set_cfg(1, 0, 5, 0);
    @(posedge clk); #1;
    chk(div_o == int_n, "R8 stale clear", div_o, int_n);
    count_n1(5, c); chk(c == 1, "R8 R9 after clear", c, 1);

    // R2 random configurations with per-cycle random symbols
    for (int k = 0; k < 300; k++) begin
      int n, cc, dd;
      @(negedge clk);
      n  = ($urandom_range(0, 7) == 0) ? 0 : $urandom_range(1, 4095);
      cc = (n == 0) ? $urandom_range(0, 4095) : $urandom_range(0, n - 1);
      dd = $urandom_range(0, 1023) >> $urandom_range(0, 9);
      int_n = 16'($urandom_range(0, 65534));
      set_cfg(cc, dd, n, $urandom_range(0, 7) == 0);
      for (int j = 0; j < 40; j++) begin
        @(negedge clk); data = $urandom_range(0, 1);
      end
    end

    // R1 reset mid-run returns output to N
    @(negedge clk); rst_n = 0;
    @(posedge clk); #1;
    chk(div_o == {1'b0, int_n}, "R1 mid-run reset", div_o, int_n);
    @(negedge clk); rst_n = 1;
    repeat (5) @(negedge clk);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule